// File: doc/BRIEF.md
# Modulo Counter Overflow Alarm Timer

This block is an alarm timer that software reaches through a small register interface. A 16-bit up-counter is clocked by a selectable tick source and a power-of-two prescaler. It climbs to a programmable limit and then reloads a programmable start value. On that reload the block sets a sticky overflow flag, which can raise an interrupt line. Software uses it as a one-shot alarm: it stops the counter, loads the limit with the wanted tick count minus one, loads the counter and starts the source. The interrupt then arrives after exactly that many prescaled ticks.

Every bus access completes in one cycle. A write is taken on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`. The fixed-frequency source and the external source are synchronous enable pulses, one clock wide, in the block's own clock domain.

Top module: `ovf_alarm_timer`

## Requirements
- R1: Registers sit at byte offsets 0x00 (control/status), 0x04 (count), 0x08 (limit) and 0x4C (start value). Control/status holds prescale in bits 2:0, source in bits 4:3, interrupt enable in bit 6 and overflow flag in bit 7. Every other bit, and every other offset, reads as zero.
- R2: Source code 0 holds the counter at its value and clears the prescaler, so that a restart always begins a full prescale period.
- R3: Source code 1 ticks on every clock, code 2 on each `fix_tick` pulse and code 3 on each `ext_tick` pulse. Pulses on the input that is not selected have no effect.
- R4: The prescaler passes one counter step for every 2^PS source ticks, where PS is the value of bits 2:0 (0 to 7).
- R5: On each counter step the count increments while it differs from the limit. When it equals the limit, it reloads the start value instead. A limit of N-1 with start 0 therefore overflows on the N-th step.
- R6: The overflow flag is set on the step in which the count reloads from the limit to the start value.
- R7: Any write to the count register loads the start value, whatever the written data. Such a write wins over a simultaneous counter step, and that step raises no overflow.
- R8: The limit and start registers store only the low 16 bits of the written data. Their upper bits read as zero.
- R9: A control write with bit 7 = 0 clears the flag. A control write with bit 7 = 1 leaves the flag unchanged.
- R10: An overflow in the same cycle as a clearing control write leaves the flag set.
- R11: `irq` is high exactly while the flag and the interrupt enable are both set.
- R12: After reset, control/status reads 0, count 0, limit 0xFFFF and start value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` |
| fix_tick | input | 1 | Fixed-frequency tick enable pulse |
| ext_tick | input | 1 | External tick enable pulse |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, 32-bit data, an 8-bit address and the external source present. With these parameters every prescale setting from 0 to 7 can be swept against several limit values on the per-clock source. The bench predicts the overflow cycle as limit-plus-one times 2^PS, so the largest case needs only a few hundred clocks. The small limits also make it easy to place a counter load or a flag clear on the exact cycle of an overflow. The two pulse sources are driven by hand, which makes it possible to count pulses and to show that the source that is not selected is ignored.

// File: rtl/ovt_pkg.sv
`timescale 1ns/1ps
package ovt_pkg;

   // register byte offsets (software-visible map)
   localparam int unsigned OFS_CTRL  = 32'h00;
   localparam int unsigned OFS_COUNT = 32'h04;
   localparam int unsigned OFS_LIMIT = 32'h08;
   localparam int unsigned OFS_START = 32'h4C;

   // control/status field positions
   localparam int unsigned PS_W        = 3;
   localparam int unsigned CF_PS_LSB   = 0;
   localparam int unsigned CF_SRC_LSB  = 3;
   localparam int unsigned CF_IE_BIT   = 6;
   localparam int unsigned CF_FLAG_BIT = 7;

   typedef enum logic [1:0] {
      SRC_OFF   = 2'd0,
      SRC_CORE  = 2'd1,
      SRC_FIXED = 2'd2,
      SRC_EXT   = 2'd3
   } src_sel_e;

endpackage

// File: rtl/ovt_prescaler.sv
`timescale 1ns/1ps
module ovt_prescaler
   import ovt_pkg::*;
#(
   parameter int unsigned PSC_W      = 3,
   parameter bit          EXT_SRC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  src_sel_e         src,
   input  logic [PSC_W-1:0] ps,
   input  logic             fix_tick,
   input  logic             ext_tick,
   output logic             step
);

   localparam int unsigned PRE_W = (1 << PSC_W) - 1;

   logic             src_tick;
   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] lim;
   logic             wrap;

   generate
      if (PSC_W < 1 || PSC_W > 4) begin : g_bad_ps
         $error("ovt_prescaler: PSC_W out of range");
      end
      if (EXT_SRC_EN) begin : g_ext
         always_comb begin
            unique case (src)
               SRC_CORE:  src_tick = 1'b1;
               SRC_FIXED: src_tick = fix_tick;
               SRC_EXT:   src_tick = ext_tick;
               default:   src_tick = 1'b0;
            endcase
         end
      end else begin : g_noext
         logic unused_ext;
         assign unused_ext = ext_tick;
         always_comb begin
            unique case (src)
               SRC_CORE:  src_tick = 1'b1;
               SRC_FIXED: src_tick = fix_tick;
               default:   src_tick = 1'b0;
            endcase
         end
      end
   endgenerate

   // terminal value of the prescale counter: 2^ps - 1
   assign lim  = ~({PRE_W{1'b1}} << ps);
   assign wrap = (pre_q >= lim);
   assign step = src_tick && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (src == SRC_OFF) begin
         pre_q <= '0;
      end else if (src_tick) begin
         pre_q <= wrap ? '0 : pre_q + 1'b1;
      end
   end

   // R2: a stopped source leaves the prescaler at zero on the next edge
   a_r2_pre_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_OFF) |=> (pre_q == '0));

   // R4: prescaler never rests beyond its terminal value while running
   a_r4_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (src_tick && $stable(ps)) |=> (pre_q <= lim || $changed(ps)));

endmodule

// File: rtl/ovt_counter.sv
`timescale 1ns/1ps
module ovt_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             cnt_wr,
   input  logic             lim_wr,
   input  logic             start_wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] start,
   output logic             ovf
);

   logic at_lim;

   assign at_lim = (count == limit);
   assign ovf    = step && at_lim && !cnt_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit <= '1;
         start <= '0;
      end else begin
         if (lim_wr)   limit <= wdata;
         if (start_wr) start <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (cnt_wr) begin
         count <= start;
      end else if (step) begin
         count <= at_lim ? start : count + 1'b1;
      end
   end

   // R5: a step below the limit moves the count up by one
   a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cnt_wr && !ovf) |=> (count == $past(count) + CNT_W'(1)));

   // R5: an overflow lands the count on the start value
   a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (count == $past(start)));

   // R7: a count write loads the start value
   a_r7_wr_load: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (count == $past(start)));

   // R5: without a step or write the count holds
   a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !cnt_wr) |=> $stable(count));

endmodule

// File: rtl/ovt_ctrl.sv
`timescale 1ns/1ps
module ovt_ctrl
   import ovt_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctl_wr,
   input  logic [7:0]      wdata,
   input  logic            ovf,
   output logic [PS_W-1:0] ps,
   output src_sel_e        src,
   output logic            ie,
   output logic            flag,
   output logic            irq
);

   logic unused_b5;
   assign unused_b5 = wdata[5];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps  <= '0;
         src <= SRC_OFF;
         ie  <= 1'b0;
      end else if (ctl_wr) begin
         ps  <= wdata[CF_PS_LSB +: PS_W];
         src <= src_sel_e'(wdata[CF_SRC_LSB +: 2]);
         ie  <= wdata[CF_IE_BIT];
      end
   end

   // overflow event outranks a clearing write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (ovf) begin
         flag <= 1'b1;
      end else if (ctl_wr && !wdata[CF_FLAG_BIT]) begin
         flag <= 1'b0;
      end
   end

   assign irq = flag && ie;

   // R6 / R10: an overflow always leaves the flag set
   a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> flag);

   // R9: writing zero to the flag bit clears it
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !wdata[CF_FLAG_BIT] && !ovf) |=> !flag);

   // R9: writing one to the flag bit keeps it
   a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wdata[CF_FLAG_BIT] && !ovf) |=> (flag == $past(flag)));

endmodule

// File: rtl/ovf_alarm_timer.sv
`timescale 1ns/1ps
module ovf_alarm_timer
   import ovt_pkg::*;
#(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 8,
   parameter bit          EXT_SRC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              fix_tick,
   input  logic              ext_tick,
   output logic              irq
);

   generate
      if (CNT_W < 8 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("ovf_alarm_timer: CNT_W must lie in 8..DATA_W");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("ovf_alarm_timer: ADDR_W too small for the register map");
      end
   endgenerate

   logic hit_ctrl, hit_cnt, hit_lim, hit_start;
   logic [PS_W-1:0]  ps;
   src_sel_e         src;
   logic             ie, flag, step, ovf;
   logic [CNT_W-1:0] count, limit, start;
   logic             unused_wdata;

   assign unused_wdata = ^bus_wdata;

   assign hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_cnt   = (bus_addr == ADDR_W'(OFS_COUNT));
   assign hit_lim   = (bus_addr == ADDR_W'(OFS_LIMIT));
   assign hit_start = (bus_addr == ADDR_W'(OFS_START));

   ovt_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl_wr (bus_wr && hit_ctrl),
      .wdata  (bus_wdata[7:0]),
      .ovf    (ovf),
      .ps     (ps),
      .src    (src),
      .ie     (ie),
      .flag   (flag),
      .irq    (irq)
   );

   ovt_prescaler #(
      .PSC_W      (PS_W),
      .EXT_SRC_EN (EXT_SRC_EN)
   ) u_psc (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (src),
      .ps       (ps),
      .fix_tick (fix_tick),
      .ext_tick (ext_tick),
      .step     (step)
   );

   ovt_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .cnt_wr   (bus_wr && hit_cnt),
      .lim_wr   (bus_wr && hit_lim),
      .start_wr (bus_wr && hit_start),
      .wdata    (bus_wdata[CNT_W-1:0]),
      .count    (count),
      .limit    (limit),
      .start    (start),
      .ovf      (ovf)
   );

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl) begin
         bus_rdata[CF_PS_LSB +: PS_W] = ps;
         bus_rdata[CF_SRC_LSB +: 2]   = src;
         bus_rdata[CF_IE_BIT]         = ie;
         bus_rdata[CF_FLAG_BIT]       = flag;
      end else if (hit_cnt) begin
         bus_rdata[CNT_W-1:0] = count;
      end else if (hit_lim) begin
         bus_rdata[CNT_W-1:0] = limit;
      end else if (hit_start) begin
         bus_rdata[CNT_W-1:0] = start;
      end
   end

   // R2: a stopped source keeps the count unless software loads it
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_OFF && !(bus_wr && hit_cnt)) |=> $stable(count));

   // R6: the flag only rises on an overflow from the counter
   a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(ovf));

endmodule

// File: tb/ovf_alarm_timer_tb.sv
`timescale 1ns/1ps
module ovf_alarm_timer_tb;

   localparam logic [7:0] A_CTRL  = 8'h00;
   localparam logic [7:0] A_COUNT = 8'h04;
   localparam logic [7:0] A_LIMIT = 8'h08;
   localparam logic [7:0] A_START = 8'h4C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        fix_tick = 1'b0;
   logic        ext_tick = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   ovf_alarm_timer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .fix_tick  (fix_tick),
      .ext_tick  (ext_tick),
      .irq       (irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // called at a falling edge, returns at the next falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      bus_addr = a;
      #0.2;
      v = bus_rdata;
   endtask

   task automatic run_until_flag(output int cyc);
      logic [31:0] v;
      cyc = 0;
      do begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         rd(A_CTRL, v);
      end while (!v[7] && cyc < 4000);
   endtask

   // stop, clear the flag, program limit/start and reload the count
   task automatic arm(input logic [31:0] lim, input logic [31:0] st);
      wr(A_CTRL, 32'h0);
      wr(A_LIMIT, lim);
      wr(A_START, st);
      wr(A_COUNT, 32'h0);
   endtask

   task automatic pulse(input bit on_fix);
      if (on_fix) fix_tick = 1'b1; else ext_tick = 1'b1;
      @(negedge clk);
      fix_tick = 1'b0; ext_tick = 1'b0;
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int cyc;
      int np;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset values
      rd(A_CTRL, v);  chk("R12 ctrl reset", v, 32'h0);
      rd(A_COUNT, v); chk("R12 count reset", v, 32'h0);
      rd(A_LIMIT, v); chk("R12 limit reset", v, 32'h0000FFFF);
      rd(A_START, v); chk("R12 start reset", v, 32'h0);
      chk("R12 irq reset", {31'b0, irq}, 32'h0);

      // R1 unmapped offset and control field layout
      rd(8'h10, v); chk("R1 unmapped reads zero", v, 32'h0);
      wr(A_CTRL, 32'hFFFF_FF7F);
      rd(A_CTRL, v); chk("R1 ctrl readback", v, 32'h0000005F);
      wr(A_CTRL, 32'h0);

      // R8 only low 16 bits kept
      wr(A_LIMIT, 32'hFFFF_0003);
      rd(A_LIMIT, v); chk("R8 limit upper bits", v, 32'h00000003);
      wr(A_START, 32'hABCD_5678);
      rd(A_START, v); chk("R8 start upper bits", v, 32'h00005678);

      // R7 count write loads start value, not the data
      wr(A_START, 32'h1234);
      wr(A_COUNT, 32'hABCD);
      rd(A_COUNT, v); chk("R7 count write loads start", v, 32'h1234);

      // R4 R5 R6 sweep prescale and limit on the per-clock source
      for (int ps = 0; ps < 8; ps++) begin
         for (int k = 0; k < 3; k++) begin
            int n;
            n = (k == 0) ? 1 : (k == 1) ? 2 : 5;
            arm(n - 1, 0);
            wr(A_CTRL, 32'h08 | ps);
            run_until_flag(cyc);
            chk($sformatf("R4 R5 R6 ps=%0d n=%0d", ps, n), cyc, n * (1 << ps));
         end
      end

      // R5 reload lands on start value
      arm(8, 5);
      wr(A_CTRL, 32'h08);
      run_until_flag(cyc);
      chk("R5 ticks from start to limit", cyc, 4);
      rd(A_COUNT, v); chk("R5 count after reload", v, 32'h5);

      // R2 stopped source holds count
      arm(32'hFFFF, 0);
      wr(A_CTRL, 32'h08);
      repeat (5) @(negedge clk);
      wr(A_CTRL, 32'h0);
      rd(A_COUNT, v);
      repeat (10) @(negedge clk);
      begin
         logic [31:0] v2;
         rd(A_COUNT, v2);
         chk("R2 count held while stopped", v2, v);
      end

      // R2 prescaler restarts from a full period
      arm(32'hFFFF, 0);
      wr(A_CTRL, 32'h0A);
      repeat (2) @(negedge clk);
      arm(0, 0);
      wr(A_CTRL, 32'h0A);
      run_until_flag(cyc);
      chk("R2 prescaler cleared on stop", cyc, 4);

      // R3 fixed source counts its pulses, external pulses ignored
      arm(3, 0);
      wr(A_CTRL, 32'h11);
      for (int i = 0; i < 20; i++) pulse(1'b0);
      rd(A_COUNT, v); chk("R3 ext ignored on fixed source", v, 32'h0);
      np = 0;
      do begin
         pulse(1'b1); np++;
         rd(A_CTRL, v);
         @(negedge clk);
      end while (!v[7] && np < 100);
      chk("R3 fixed source pulse count", np, 8);

      // R3 external source counts its pulses, fixed pulses ignored
      arm(3, 0);
      wr(A_CTRL, 32'h19);
      for (int i = 0; i < 20; i++) pulse(1'b1);
      rd(A_COUNT, v); chk("R3 fixed ignored on ext source", v, 32'h0);
      np = 0;
      do begin
         pulse(1'b0); np++;
         rd(A_CTRL, v);
         @(negedge clk);
      end while (!v[7] && np < 100);
      chk("R3 ext source pulse count", np, 8);

      // R9 write one keeps, write zero clears
      wr(A_CTRL, 32'h80);
      rd(A_CTRL, v); chk("R9 write one keeps flag", v[7], 1);
      // R11 irq follows flag and enable
      wr(A_CTRL, 32'hC0);
      chk("R11 irq with flag and enable", {31'b0, irq}, 32'h1);
      wr(A_CTRL, 32'h80);
      chk("R11 irq off without enable", {31'b0, irq}, 32'h0);
      wr(A_CTRL, 32'h40);
      rd(A_CTRL, v); chk("R9 write zero clears flag", v[7], 0);
      chk("R11 irq off without flag", {31'b0, irq}, 32'h0);

      // R7 count write beats a simultaneous step, no overflow
      arm(0, 0);
      wr(A_CTRL, 32'h08);
      wr(A_COUNT, 32'h0);
      rd(A_CTRL, v);
      chk("R7 write over step raises nothing", v[7], 0);

      // R10 overflow and clear in the same cycle
      arm(3, 0);
      wr(A_CTRL, 32'h08);
      wr(A_COUNT, 32'h0);
      repeat (3) @(negedge clk);
      wr(A_CTRL, 32'h08);
      rd(A_CTRL, v);
      chk("R10 overflow beats clear", v[7], 1);
      wr(A_CTRL, 32'h0);
      rd(A_CTRL, v);
      chk("R9 clear after collision", v[7], 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule